// File: doc/BRIEF.md
# USB Controller Status Register

This block holds the 32-bit status word of a USB host/device controller. It gathers the per-endpoint NAK conditions into one summary interrupt bit. It mirrors the real enable state of the asynchronous and periodic schedules, which the schedule engines acknowledge some time after software changes the command enables. It also reports the halted, reclamation, device-suspend, ULPI-event and start-of-frame conditions.

Software clears the event bits through a one-cycle register write, using write-1-to-clear. Every other status bit is a level that the block derives from its hardware inputs, so software writes have no effect on those bits. Every status bit is registered, so each input is seen on `status` one clock after it is sampled.

Top module: `usb_ctrl_status`

## Requirements
- R1: Bit 16 (endpoint NAK summary) reads 1 one clock after any endpoint has both its NAK flag and its matching enable set, on either the transmit or the receive side. It returns to 0 by itself one clock after no such endpoint remains, and no write is needed to clear it.
- R2: An endpoint whose NAK flag is set while its enable bit is clear does not set bit 16.
- R3: Bit 15 (asynchronous schedule running) equals the asynchronous acknowledge input as sampled one clock earlier.
- R4: Bit 14 (periodic schedule running) equals the periodic acknowledge input as sampled one clock earlier.
- R5: Bit 13 (reclamation) reads 1 one clock after the asynchronous-schedule-empty input is 1, and reads 0 one clock after that input is 0.
- R6: Bit 12 (halted) clears one clock after `run_cmd` is 1. It sets one clock after `ctrl_stopped` is 1 while `run_cmd` is 0. Otherwise it holds its value. When both inputs are 1, `run_cmd` wins.
- R7: Bit 10 (ULPI event) sets one clock after a `ulpi_done` pulse and stays set. A write with `wr_data[10]`=1 clears it. A write with `wr_data[10]`=0 leaves it unchanged. If a set and a clear fall in the same clock, the set wins.
- R8: Bit 8 (device suspended) reads 1 one clock after `dev_suspended` goes high and 0 one clock after it goes low.
- R9: Bit 7 (frame tick) sets one clock after a `sof_tick` pulse and stays set. A write with `wr_data[7]`=1 clears it. A write with `wr_data[7]`=0 leaves it unchanged. If a set and a clear fall in the same clock, the set wins.
- R10: Bits 31–17, 11, 9 and 6–0 always read 0.
- R11: A write has no effect on bits 16, 15, 14, 13, 12 or 8, whatever value it carries in those positions.
- R12: While `rst` is high, bit 12 reads 1 and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ep_tx_nak | input | NUM_EP | Transmit endpoint NAK flags |
| ep_rx_nak | input | NUM_EP | Receive endpoint NAK flags |
| ep_tx_nak_en | input | NUM_EP | Transmit endpoint NAK enables |
| ep_rx_nak_en | input | NUM_EP | Receive endpoint NAK enables |
| async_ack | input | 1 | Asynchronous schedule engine reports it is running |
| periodic_ack | input | 1 | Periodic schedule engine reports it is running |
| async_empty | input | 1 | Asynchronous schedule found empty |
| run_cmd | input | 1 | Run/stop command bit |
| ctrl_stopped | input | 1 | Controller has stopped executing |
| ulpi_done | input | 1 | ULPI event completion pulse |
| dev_suspended | input | 1 | Device controller is in suspend |
| sof_tick | input | 1 | Start-of-frame or frame-time pulse |
| wr_en | input | 1 | Status register write strobe |
| wr_data | input | 32 | Write data; a 1 clears the matching event bit |
| status | output | 32 | Status word |

## Verification
The assertions check on every cycle these properties: the NAK summary follows an enabled endpoint hit, the schedule bits follow their acknowledges, the halted bit clears after run and holds when neither of its inputs is active, set-wins on the event bits, a clear taking effect, and the reserved bits staying zero. Only the bench scenarios can show these properties: an event bit staying set across many idle cycles, a zero write leaving it alone, writes to the level bits having no visible effect, a disabled endpoint being masked, and the reset values.

// File: rtl/usbsts_pkg.sv
package usbsts_pkg;
  localparam int STS_W   = 32;
  localparam int B_NAK   = 16;
  localparam int B_ASYNC = 15;
  localparam int B_PER   = 14;
  localparam int B_RECL  = 13;
  localparam int B_HALT  = 12;
  localparam int B_ULPI  = 10;
  localparam int B_SUSP  = 8;
  localparam int B_SOF   = 7;
  localparam logic [STS_W-1:0] LIVE_MASK =
    (32'h1 << B_NAK) | (32'h1 << B_ASYNC) | (32'h1 << B_PER) |
    (32'h1 << B_RECL) | (32'h1 << B_HALT) | (32'h1 << B_ULPI) |
    (32'h1 << B_SUSP) | (32'h1 << B_SOF);
endpackage

// File: rtl/usbsts_nak_sum.sv
module usbsts_nak_sum #(
  parameter int NUM_EP = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EP-1:0] tx_nak,
  input  logic [NUM_EP-1:0] rx_nak,
  input  logic [NUM_EP-1:0] tx_en,
  input  logic [NUM_EP-1:0] rx_en,
  output logic              nak_q
);
  localparam int HITS = 2 * NUM_EP;

  logic [HITS-1:0] hit;

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    assign hit[2*e]   = tx_nak[e] & tx_en[e];
    assign hit[2*e+1] = rx_nak[e] & rx_en[e];
  end

  always_ff @(posedge clk) begin
    if (rst) nak_q <= 1'b0;
    else     nak_q <= |hit;
  end

  assert_nak_sets_R1: assert property (@(posedge clk) disable iff (rst)
    ((tx_nak & tx_en) != '0 || (rx_nak & rx_en) != '0) |=> nak_q);
  assert_nak_clears_R1: assert property (@(posedge clk) disable iff (rst)
    ((tx_nak & tx_en) == '0 && (rx_nak & rx_en) == '0) |=> !nak_q);
endmodule

// File: rtl/usbsts_sched.sv
module usbsts_sched (
  input  logic clk,
  input  logic rst,
  input  logic async_ack,
  input  logic periodic_ack,
  input  logic async_empty,
  input  logic run_cmd,
  input  logic ctrl_stopped,
  output logic async_q,
  output logic per_q,
  output logic recl_q,
  output logic halt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      async_q <= 1'b0;
      per_q   <= 1'b0;
      recl_q  <= 1'b0;
      halt_q  <= 1'b1;
    end else begin
      async_q <= async_ack;
      per_q   <= periodic_ack;
      recl_q  <= async_empty;
      if (run_cmd)           halt_q <= 1'b0;
      else if (ctrl_stopped) halt_q <= 1'b1;
    end
  end

  assert_async_follows_R3: assert property (@(posedge clk) disable iff (rst)
    async_ack |=> async_q);
  assert_per_follows_R4: assert property (@(posedge clk) disable iff (rst)
    !periodic_ack |=> !per_q);
  assert_halt_clears_R6: assert property (@(posedge clk) disable iff (rst)
    run_cmd |=> !halt_q);
  assert_halt_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (!run_cmd && !ctrl_stopped) |=> $stable(halt_q));
endmodule

// File: rtl/usbsts_w1c_bit.sv
module usbsts_w1c_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_q);
  assert_clear_takes_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_q);
endmodule

// File: rtl/usb_ctrl_status.sv
module usb_ctrl_status
  import usbsts_pkg::*;
#(
  parameter int NUM_EP = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EP-1:0] ep_tx_nak,
  input  logic [NUM_EP-1:0] ep_rx_nak,
  input  logic [NUM_EP-1:0] ep_tx_nak_en,
  input  logic [NUM_EP-1:0] ep_rx_nak_en,
  input  logic              async_ack,
  input  logic              periodic_ack,
  input  logic              async_empty,
  input  logic              run_cmd,
  input  logic              ctrl_stopped,
  input  logic              ulpi_done,
  input  logic              dev_suspended,
  input  logic              sof_tick,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       status
);
  localparam logic [31:0] CLR_MASK = (32'h1 << B_ULPI) | (32'h1 << B_SOF);

  logic nak_q, async_q, per_q, recl_q, halt_q, ulpi_q, sof_q, susp_q;
  logic [31:0] clr_req;

  assign clr_req = wr_en ? (wr_data & CLR_MASK) : 32'h0;

  usbsts_nak_sum #(.NUM_EP(NUM_EP)) u_nak (
    .clk(clk), .rst(rst),
    .tx_nak(ep_tx_nak), .rx_nak(ep_rx_nak),
    .tx_en(ep_tx_nak_en), .rx_en(ep_rx_nak_en),
    .nak_q(nak_q)
  );

  usbsts_sched u_sched (
    .clk(clk), .rst(rst),
    .async_ack(async_ack), .periodic_ack(periodic_ack),
    .async_empty(async_empty), .run_cmd(run_cmd),
    .ctrl_stopped(ctrl_stopped),
    .async_q(async_q), .per_q(per_q), .recl_q(recl_q), .halt_q(halt_q)
  );

  usbsts_w1c_bit u_ulpi (
    .clk(clk), .rst(rst), .set_i(ulpi_done),
    .clr_i(clr_req[B_ULPI]), .flag_q(ulpi_q)
  );

  usbsts_w1c_bit u_sof (
    .clk(clk), .rst(rst), .set_i(sof_tick),
    .clr_i(clr_req[B_SOF]), .flag_q(sof_q)
  );

  always_ff @(posedge clk) begin
    if (rst) susp_q <= 1'b0;
    else     susp_q <= dev_suspended;
  end

  always_comb begin
    status         = '0;
    status[B_NAK]  = nak_q;
    status[B_ASYNC]= async_q;
    status[B_PER]  = per_q;
    status[B_RECL] = recl_q;
    status[B_HALT] = halt_q;
    status[B_ULPI] = ulpi_q;
    status[B_SUSP] = susp_q;
    status[B_SOF]  = sof_q;
  end

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (status & ~LIVE_MASK) == 32'h0);
  assert_sof_cleared_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ((wr_data & (32'h1 << B_SOF)) != 32'h0) && !sof_tick) |=> !status[B_SOF]);
  assert_susp_follows_R8: assert property (@(posedge clk) disable iff (rst)
    dev_suspended |=> status[B_SUSP]);
endmodule

// File: tb/sim_usb_ctrl_status.sv
`timescale 1ns/100ps
module sim_usb_ctrl_status;
  localparam int NEP = 8;

  logic clk = 1'b0;
  logic rst;
  logic [NEP-1:0] txn, rxn, txe, rxe;
  logic aack, pack, aempty, run, stopped, udone, susp, sof, wen;
  logic [31:0] wdata;
  logic [31:0] status;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  usb_ctrl_status #(.NUM_EP(NEP)) u0 (
    .clk(clk), .rst(rst),
    .ep_tx_nak(txn), .ep_rx_nak(rxn), .ep_tx_nak_en(txe), .ep_rx_nak_en(rxe),
    .async_ack(aack), .periodic_ack(pack), .async_empty(aempty),
    .run_cmd(run), .ctrl_stopped(stopped), .ulpi_done(udone),
    .dev_suspended(susp), .sof_tick(sof), .wr_en(wen), .wr_data(wdata),
    .status(status)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // inputs change at negedge; one posedge later the result is sampled at the next negedge
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle_pulses();
    udone = 0; sof = 0; wen = 0; wdata = '0; run = 0; stopped = 0;
  endtask

  task automatic t_reset();
    rst = 1; txn = '0; rxn = '0; txe = '0; rxe = '0;
    aack = 1; pack = 1; aempty = 1; susp = 1; udone = 1; sof = 1;
    run = 1; stopped = 0; wen = 0; wdata = '0;
    tick(); tick();
    chk("R12 reset value", status, 32'h0000_1000);
    aack = 0; pack = 0; aempty = 0; susp = 0; idle_pulses();
    tick();
    rst = 0;
    tick();
    chk("R12 after release", status, 32'h0000_1000);
  endtask

  task automatic t_nak();
    txn = 8'h04; txe = 8'h00; tick();
    chk("R2 masked tx flag", status & 32'h1_0000, 32'h0);
    rxn = 8'h80; txe = 8'h01; tick();
    chk("R2 enable on other endpoint", status & 32'h1_0000, 32'h0);
    rxe = 8'h80; tick();
    chk("R1 rx hit sets", status & 32'h1_0000, 32'h1_0000);
    rxn = 8'h00; txe = 8'h04; tick();
    chk("R1 tx hit holds", status & 32'h1_0000, 32'h1_0000);
    txn = 8'h00; tick();
    chk("R1 self clear", status & 32'h1_0000, 32'h0);
    txe = '0; rxe = '0;
  endtask

  task automatic t_sched();
    aack = 1; tick();
    chk("R3 async on", status & 32'h0000_C000, 32'h0000_8000);
    pack = 1; aack = 0; tick();
    chk("R4 periodic on, R3 async off", status & 32'h0000_C000, 32'h0000_4000);
    pack = 0; aempty = 1; tick();
    chk("R5 reclamation set", status & 32'h0000_6000, 32'h0000_2000);
    aempty = 0; tick();
    chk("R5 reclamation clear", status & 32'h0000_2000, 32'h0);
  endtask

  task automatic t_halt();
    run = 1; tick();
    chk("R6 run clears halt", status & 32'h1000, 32'h0);
    run = 0; tick(); tick();
    chk("R6 halt stays clear until stop", status & 32'h1000, 32'h0);
    stopped = 1; tick();
    chk("R6 stop sets halt", status & 32'h1000, 32'h1000);
    stopped = 0; tick();
    chk("R6 halt holds", status & 32'h1000, 32'h1000);
    run = 1; stopped = 1; tick();
    chk("R6 run wins over stop", status & 32'h1000, 32'h0);
    run = 0; stopped = 0;
  endtask

  task automatic t_ulpi();
    udone = 1; tick(); udone = 0;
    chk("R7 ulpi set", status & 32'h400, 32'h400);
    tick(); tick();
    chk("R7 ulpi sticky", status & 32'h400, 32'h400);
    wen = 1; wdata = 32'hFFFF_FBFF; tick();
    chk("R7 zero write keeps ulpi", status & 32'h400, 32'h400);
    wdata = 32'h400; udone = 1; tick();
    chk("R7 set wins over clear", status & 32'h400, 32'h400);
    udone = 0; tick(); wen = 0; wdata = '0;
    chk("R7 write-1 clears", status & 32'h400, 32'h0);
  endtask

  task automatic t_sof();
    sof = 1; tick(); sof = 0;
    chk("R9 sof set", status & 32'h80, 32'h80);
    wen = 1; wdata = 32'h400; tick();
    chk("R9 other-bit write keeps sof", status & 32'h80, 32'h80);
    wdata = 32'h80; sof = 1; tick();
    chk("R9 set wins over clear", status & 32'h80, 32'h80);
    sof = 0; tick(); wen = 0; wdata = '0;
    chk("R9 write-1 clears", status & 32'h80, 32'h0);
  endtask

  task automatic t_susp();
    susp = 1; tick();
    chk("R8 suspend enter", status & 32'h100, 32'h100);
    susp = 0; tick();
    chk("R8 suspend exit", status & 32'h100, 32'h0);
  endtask

  task automatic t_writes();
    txn = 8'h01; txe = 8'h01; aack = 1; pack = 1; aempty = 1; susp = 1;
    stopped = 1; tick(); stopped = 0;
    chk("R11 levels before write", status, 32'h0001_F100);
    wen = 1; wdata = 32'hFFFF_FFFF; udone = 0; tick();
    chk("R11 all-ones write, R10 reserved zero", status, 32'h0001_F100);
    wdata = 32'h0; tick(); wen = 0;
    chk("R11 zero write", status, 32'h0001_F100);
    udone = 1; sof = 1; tick(); udone = 0; sof = 0;
    chk("R10 reserved zero with all bits live", status, 32'h0001_F580);
    txn = '0; txe = '0; aack = 0; pack = 0; aempty = 0; susp = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_nak();
    t_sched();
    t_halt();
    t_ulpi();
    t_sof();
    t_susp();
    t_writes();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule